// File: doc/BRIEF.md
# Slot-Gated Shared-Line Transmitter with Collision Abort

This block is the transmit-side access logic for one station on a shared, wired-AND serial line. The line is carried in one time slot of a time-division multiplexed link, and any number of stations may share that slot. The station advances only on gated bit edges. A gated bit edge is a system clock edge at which the bit-clock enable and the slot-active input are both high. At every other edge the block holds its state.

Bytes arrive on a valid/ready stream and leave least-significant bit first. The line output is a drive-low enable, so a 1 is sent by letting go of the line. A carrier-sense input echoes the shared line. At each gated edge the block compares the echo with the bit it is currently releasing. If the station has released the line but the echo reads low, another station is holding it down. The block then lets go at once, pulses a collision flag for one cycle and returns to idle. It starts again only when new bytes are offered.

A request-to-send output can follow one of two timings. It can be held for the whole frame, or it can be a short strobe that lasts two bit times at the start of the frame.

Top module: `hdlc_slot_tx`

## Requirements
- R1: After reset, and again after a reset applied in the middle of a frame, line_low_o, busy_o, rts_o and coll_o are 0 and tx_ready_o is 1.
- R2: The block changes its outputs and state only at a gated edge, where bit_en_i and slot_act_i are both 1. While either is 0, edges change nothing, and a low cts_i at such an edge raises no collision.
- R3: Bits go out least-significant first, one per gated edge. line_low_o is 1 for a 0 bit and 0 for a 1 bit. The first bit of a byte appears at the first gated edge after the byte is accepted.
- R4: A byte is accepted at a clock edge where tx_valid_i and tx_ready_o are both 1. tx_ready_o is 1 only while no bits of a byte are pending, and no byte marked last (tx_last_i = 1) is still ending. A byte accepted between the gated edge that sends the previous byte's bit 7 and the next gated edge follows with no gap.
- R5: At a gated edge inside a frame with no bits pending, and with the last byte not yet sent, the line is released (line_low_o = 0) and busy_o stays 1.
- R6: At the gated edge after bit 7 of a byte marked last, line_low_o and busy_o go to 0 (provided no collision is declared at that edge).
- R7: If, at a gated edge while busy, the bit on the line is a released 1 and cts_i reads 0, then after that edge the following hold: coll_o is 1 for exactly one cycle, line_low_o, busy_o and rts_o are 0, and the pending bits are discarded. A low cts_i while the station drives a 0 is not a collision.
- R8: With rts_short_i = 1, rts_o rises at the gated edge that sends the first bit and falls at the third gated edge, so it is high for two bit times.
- R9: With rts_short_i = 0, rts_o rises with the first bit. It stays high through underruns until the frame ends or a collision occurs.
- R10: busy_o rises at the gated edge that sends the first bit of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en_i | input | 1 | Bit-clock enable, one cycle per bit time |
| slot_act_i | input | 1 | High while the station's time slot is active |
| tx_data_i | input | DATA_W | Byte to send |
| tx_valid_i | input | 1 | tx_data_i holds a byte |
| tx_last_i | input | 1 | Byte is the final one of its frame |
| tx_ready_o | output | 1 | Block takes a byte at this edge if valid |
| cts_i | input | 1 | Echo of the shared line (0 = line low) |
| rts_short_i | input | 1 | 1 selects the two-bit request strobe |
| line_low_o | output | 1 | Drive-low enable of the open-drain line |
| rts_o | output | 1 | Request-to-send |
| busy_o | output | 1 | Frame in progress |
| coll_o | output | 1 | One-cycle collision/abort pulse |

## Verification
The shifting and collision logic is tried with a table of single-byte frames. Each frame pairs a data byte with a mask that marks the bit times at which a rival station pulls the line low. Some masks hit a 1 bit, at the first, a middle or the last position; others hit only 0 bits or nothing at all. These frames separate a real collision from a harmless low echo and confirm that the abort lands on the right bit time. Directed sequences add enable pulses outside the slot with the echo held low, a multi-byte frame with a seamless reload and an underrun gap, both request timings, and a reset in mid-frame.

// File: rtl/hdlc_slot_pkg.sv
package hdlc_slot_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    // State of the station's own contribution to the shared line
    typedef struct packed {
        logic drive_low;   // pulling the line down
        logic on_line;     // a data bit (not idle fill) is being presented
    } line_s;

    localparam line_s LINE_FREE = '{drive_low: 1'b0, on_line: 1'b0};

    // A rival holds the line low while this station releases a data bit
    function automatic logic collide(input line_s cur, input logic cts);
        return cur.on_line & ~cur.drive_low & ~cts;
    endfunction

    function automatic line_s present_bit(input logic data_bit);
        return '{drive_low: ~data_bit, on_line: 1'b1};
    endfunction

endpackage

// File: rtl/slot_gate.sv
module slot_gate (
    input  logic bit_en_i,
    input  logic slot_act_i,
    output logic tick_o
);
    // A bit edge counts only inside the station's slot
    assign tick_o = bit_en_i & slot_act_i;
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              last_i,
    input  logic              shift_i,
    input  logic              flush_i,
    output logic              empty_o,
    output logic              bit_o,
    output logic              last_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (load_i) begin
            sr_q   <= data_i;
            cnt_q  <= CNT_W'(DATA_W);
            last_q <= last_i;
        end else if (shift_i) begin
            sr_q  <= sr_q >> 1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign empty_o = (cnt_q == '0);
    assign bit_o   = sr_q[0];
    assign last_o  = last_q;

    AST_LOAD_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        load_i |-> empty_o);                                   // R4
    AST_SHIFT_HAS_BITS: assert property (@(posedge clk) disable iff (rst)
        shift_i |-> !empty_o);                                 // R3
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DATA_W));                              // R3
endmodule

// File: rtl/rts_timer.sv
module rts_timer #(
    parameter int HOLD_BITS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic adv_i,
    input  logic stop_i,
    input  logic short_i,
    output logic rts_o
);
    localparam int CW = $clog2(HOLD_BITS + 1);

    logic          rts_q;
    logic [CW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst || stop_i) begin
            rts_q  <= 1'b0;
            held_q <= '0;
        end else if (start_i) begin
            rts_q  <= 1'b1;
            held_q <= CW'(1);
        end else if (adv_i && rts_q && short_i) begin
            if (held_q == CW'(HOLD_BITS)) begin
                rts_q <= 1'b0;
            end else begin
                held_q <= held_q + 1'b1;
            end
        end
    end

    assign rts_o = rts_q;

    AST_RTS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (rts_q && short_i) |-> (held_q <= CW'(HOLD_BITS)));    // R8
    AST_RTS_DROPS_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !rts_q);                                    // R7
endmodule

// File: rtl/hdlc_slot_tx.sv
module hdlc_slot_tx
    import hdlc_slot_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int RTS_BITS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en_i,
    input  logic              slot_act_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    input  logic              tx_last_i,
    output logic              tx_ready_o,
    input  logic              cts_i,
    input  logic              rts_short_i,
    output logic              line_low_o,
    output logic              rts_o,
    output logic              busy_o,
    output logic              coll_o
);
    logic      tick;
    logic      sh_empty, sh_bit, sh_last;
    logic      sh_load, sh_shift, sh_flush;
    logic      coll_now, start_now, adv_now, end_now;
    tx_state_e state_q;
    line_s     line_q;
    logic      busy_q, coll_q;

    slot_gate i_gate (
        .bit_en_i  (bit_en_i),
        .slot_act_i(slot_act_i),
        .tick_o    (tick)
    );

    tx_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk    (clk),
        .rst    (rst),
        .load_i (sh_load),
        .data_i (tx_data_i),
        .last_i (tx_last_i),
        .shift_i(sh_shift),
        .flush_i(sh_flush),
        .empty_o(sh_empty),
        .bit_o  (sh_bit),
        .last_o (sh_last)
    );

    rts_timer #(.HOLD_BITS(RTS_BITS)) i_rts (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_now),
        .adv_i  (adv_now),
        .stop_i (sh_flush),
        .short_i(rts_short_i),
        .rts_o  (rts_o)
    );

    // Edge classification; the echo is judged against the bit already out
    assign coll_now  = tick && (state_q == ST_SEND) && collide(line_q, cts_i);
    assign start_now = tick && (state_q == ST_IDLE) && !sh_empty;
    assign adv_now   = tick && (state_q == ST_SEND) && !coll_now;
    assign end_now   = adv_now && sh_empty && sh_last;
    assign sh_shift  = (start_now || adv_now) && !sh_empty;
    assign sh_flush  = coll_now || end_now;

    assign tx_ready_o = sh_empty && !sh_last && !coll_now;
    assign sh_load    = tx_valid_i && tx_ready_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            line_q  <= LINE_FREE;
            busy_q  <= 1'b0;
            coll_q  <= 1'b0;
        end else begin
            coll_q <= coll_now;
            if (coll_now) begin
                state_q <= ST_IDLE;
                line_q  <= LINE_FREE;
                busy_q  <= 1'b0;
            end else if (start_now) begin
                state_q <= ST_SEND;
                line_q  <= present_bit(sh_bit);
                busy_q  <= 1'b1;
            end else if (adv_now) begin
                if (!sh_empty) begin
                    line_q <= present_bit(sh_bit);
                end else if (sh_last) begin
                    state_q <= ST_IDLE;
                    line_q  <= LINE_FREE;
                    busy_q  <= 1'b0;
                end else begin
                    line_q <= LINE_FREE;   // underrun: idle fill
                end
            end
        end
    end

    assign line_low_o = line_q.drive_low;
    assign busy_o     = busy_q;
    assign coll_o     = coll_q;

    AST_HOLD_OFF_EDGE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(line_q) && $stable(busy_q)));       // R2
    AST_COLL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        coll_q |=> !coll_q);                                   // R7
    AST_COLL_LETS_GO: assert property (@(posedge clk) disable iff (rst)
        coll_q |-> (!line_q.drive_low && !busy_q));            // R7
    AST_COLL_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        coll_q |-> $past(!line_q.drive_low));                  // R7
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !line_q.drive_low);                        // R6
    AST_BUSY_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
        busy_q == (state_q == ST_SEND));                       // R10
endmodule

// File: tb/test_hdlc_slot_tx.sv
`timescale 1ns/1ps
module test_hdlc_slot_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       slot_act = 1'b1;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_last = 1'b0;
    logic       tx_ready;
    logic       cts;
    logic       rts_short = 1'b1;
    logic       line_low, rts, busy, coll;
    logic       other_low = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // Wired-AND line: low if this station or a rival pulls it
    assign cts = !(line_low || other_low);

    hdlc_slot_tx i_hdlc_slot_tx (
        .clk        (clk),
        .rst        (rst),
        .bit_en_i   (bit_en),
        .slot_act_i (slot_act),
        .tx_data_i  (tx_data),
        .tx_valid_i (tx_valid),
        .tx_last_i  (tx_last),
        .tx_ready_o (tx_ready),
        .cts_i      (cts),
        .rts_short_i(rts_short),
        .line_low_o (line_low),
        .rts_o      (rts),
        .busy_o     (busy),
        .coll_o     (coll)
    );

    // {byte, rival pull mask by bit index, short strobe}
    localparam logic [16:0] VEC [0:7] = '{
        {8'hA5, 8'h00, 1'b1},
        {8'h3C, 8'hFF, 1'b1},
        {8'h00, 8'hFF, 1'b1},
        {8'hFF, 8'h80, 1'b0},
        {8'h81, 8'h01, 1'b0},
        {8'h5A, 8'h00, 1'b0},
        {8'h0F, 8'hF0, 1'b1},
        {8'hC3, 8'h40, 1'b1}
    };

    function automatic int first_hit(input logic [7:0] b, input logic [7:0] m);
        for (int i = 0; i < 8; i++) begin
            if (b[i] && m[i]) return i;
        end
        return 8;
    endfunction

    task automatic check4(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {line_low, busy, rts, coll};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: line/busy/rts/coll got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic gated_tick(input logic in_slot, input logic pull);
        @(negedge clk);
        bit_en    = 1'b1;
        slot_act  = in_slot;
        other_low = pull;
        @(posedge clk);
        #1;
        bit_en    = 1'b0;
        slot_act  = 1'b1;
        other_low = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic last);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = d;
        tx_last  = last;
        tx_valid = 1'b1;
        @(posedge clk);
        #1;
        tx_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check4("R1 reset", 4'b0000);
        check1("R1 ready after reset", tx_ready, 1'b1);

        // Table walk: R3, R7, R8, R9, R10, R6
        for (int v = 0; v < 8; v++) begin
            logic [7:0] b;
            logic [7:0] m;
            int         k;
            bit         hit;
            b = VEC[v][16:9];
            m = VEC[v][8:1];
            rts_short = VEC[v][0];
            k = first_hit(b, m);
            hit = 1'b0;
            send_byte(b, 1'b1);
            for (int t = 1; t <= 9; t++) begin
                logic pull;
                pull = (!hit && t >= 2 && m[t-2]) ? 1'b1 : 1'b0;
                gated_tick(1'b1, pull);
                if (hit) begin
                    check4("R7 stays idle after abort", 4'b0000);
                end else if (k < 8 && t == k + 2) begin
                    check4("R7 collision abort", 4'b0001);
                    hit = 1'b1;
                end else if (t <= 8) begin
                    logic exp_rts;
                    exp_rts = rts_short ? (t <= 2) : 1'b1;
                    check4(rts_short ? "R3 R8 R10 bit out" : "R3 R9 R10 bit out",
                           {~b[t-1], 1'b1, exp_rts, 1'b0});
                end else begin
                    check4("R6 frame end", 4'b0000);
                end
            end
        end

        // R2 gating: out-of-slot edges and a low echo change nothing
        rts_short = 1'b1;
        send_byte(8'h01, 1'b1);
        check1("R4 ready low while byte pending", tx_ready, 1'b0);
        for (int i = 0; i < 3; i++) begin
            gated_tick(1'b0, 1'b1);
            check4("R2 idle off-slot edge", 4'b0000);
        end
        @(negedge clk);
        bit_en = 1'b0;
        slot_act = 1'b1;
        repeat (3) @(posedge clk);
        #1 check4("R2 slot without enable", 4'b0000);
        gated_tick(1'b1, 1'b0);
        check4("R3 R8 first bit", 4'b0110);
        for (int i = 0; i < 3; i++) begin
            gated_tick(1'b0, 1'b1);
            check4("R2 R7 off-slot low echo ignored", 4'b0110);
        end
        gated_tick(1'b1, 1'b0);
        check4("R3 R8 second bit", 4'b1110);
        gated_tick(1'b1, 1'b0);
        check4("R8 strobe dropped", 4'b1100);
        repeat (6) gated_tick(1'b1, 1'b0);
        check4("R6 frame end after gating", 4'b0000);

        // R4/R5/R9: seamless reload, underrun, full-frame request
        rts_short = 1'b0;
        begin
            logic [7:0] a_b, b_b, c_b;
            a_b = 8'h96; b_b = 8'h69; c_b = 8'hF0;
            send_byte(a_b, 1'b0);
            for (int i = 0; i < 8; i++) begin
                gated_tick(1'b1, 1'b0);
                check4("R3 R9 byte A", {~a_b[i], 3'b110});
            end
            check1("R4 ready after bit 7 sent", tx_ready, 1'b1);
            send_byte(b_b, 1'b0);
            for (int i = 0; i < 8; i++) begin
                gated_tick(1'b1, 1'b0);
                check4("R4 seamless byte B", {~b_b[i], 3'b110});
            end
            gated_tick(1'b1, 1'b0);
            check4("R5 underrun releases", 4'b0110);
            gated_tick(1'b1, 1'b0);
            check4("R5 R9 underrun holds", 4'b0110);
            send_byte(c_b, 1'b1);
            for (int i = 0; i < 8; i++) begin
                gated_tick(1'b1, 1'b0);
                check4("R3 byte C", {~c_b[i], 3'b110});
            end
            gated_tick(1'b1, 1'b0);
            check4("R6 R9 end after multi-byte", 4'b0000);
        end

        // R1 reset in mid-frame
        send_byte(8'h00, 1'b1);
        gated_tick(1'b1, 1'b0);
        gated_tick(1'b1, 1'b0);
        check4("R10 busy before reset", 4'b1110);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        check4("R1 mid-frame reset", 4'b0000);
        check1("R1 ready after mid-frame reset", tx_ready, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule